// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the serial test port of a device: a 16-state controller steered by a mode input, a 3-bit instruction register, and three data registers that can be placed between the serial input and the serial output. These are a single-bit pass-through register, a fixed 32-bit identification word, and a boundary register. The boundary register snapshots the device's parallel pin values and can preload values for the device's outputs. One instruction floats every functional output. Another drives an output vector from an update stage behind the boundary register.

The mode and serial inputs are sampled on the rising test-clock edge. The serial output is launched on the falling edge. There is no dedicated test reset: the port starts in Test-Logic-Reset at power-up (`por_n` low), and it can always be returned there by holding the mode input high. Instruction codes are 000 EXTEST, 001 IDCODE, 010 SAMPLE-Z and 100 SAMPLE/PRELOAD. All other codes (011, 101, 110, 111) select the pass-through register.

Controller states, with the next state for mode 0 / mode 1:

| State | mode=0 | mode=1 |
|---|---|---|
| ST_RESET (Test-Logic-Reset) | ST_IDLE | ST_RESET |
| ST_IDLE (Run-Test/Idle) | ST_IDLE | ST_DR_SCAN |
| ST_DR_SCAN (Select-DR) | ST_DR_CAPTURE | ST_IR_SCAN |
| ST_DR_CAPTURE | ST_DR_SHIFT | ST_DR_EXIT1 |
| ST_DR_SHIFT | ST_DR_SHIFT | ST_DR_EXIT1 |
| ST_DR_EXIT1 | ST_DR_PAUSE | ST_DR_UPDATE |
| ST_DR_PAUSE | ST_DR_PAUSE | ST_DR_EXIT2 |
| ST_DR_EXIT2 | ST_DR_SHIFT | ST_DR_UPDATE |
| ST_DR_UPDATE | ST_IDLE | ST_DR_SCAN |
| ST_IR_SCAN (Select-IR) | ST_IR_CAPTURE | ST_RESET |
| ST_IR_CAPTURE | ST_IR_SHIFT | ST_IR_EXIT1 |
| ST_IR_SHIFT | ST_IR_SHIFT | ST_IR_EXIT1 |
| ST_IR_EXIT1 | ST_IR_PAUSE | ST_IR_UPDATE |
| ST_IR_PAUSE | ST_IR_PAUSE | ST_IR_EXIT2 |
| ST_IR_EXIT2 | ST_IR_SHIFT | ST_IR_UPDATE |
| ST_IR_UPDATE | ST_IDLE | ST_DR_SCAN |

Top module: `scan_tap_top`

## Requirements
- R1: `tms` and `tdi` are sampled on the rising `tck` edge. `tdo` and `tdo_en` change only on the falling edge. `tdo_en` is 1 exactly while the controller is in ST_IR_SHIFT or ST_DR_SHIFT.
- R2: `por_n` low forces ST_RESET. From any state, five consecutive rising edges with `tms`=1 reach ST_RESET, and four do not always do so.
- R3: The instruction register is 3 bits wide and is loaded with 001 (IDCODE) whenever ST_RESET is entered or held.
- R4: On the rising edge that leaves ST_IR_CAPTURE, the instruction shift stage loads 001 (bit 0 = 1, bits 2:1 = 0). It shifts bit 0 first toward `tdo`, with `tdi` entering bit 2.
- R5: A shifted instruction takes effect only on the edge entering ST_IR_UPDATE. Until then the previous instruction stays active, including while in ST_IR_PAUSE.
- R6: Codes 011, 101, 110 and 111 select a 1-bit pass-through register. It captures 0, so the first bit out is 0 and each later bit equals `tdi` one shift earlier.
- R7: IDCODE (001) captures the 32-bit constant `ID_VAL` and shifts it out bit 0 first.
- R8: SAMPLE/PRELOAD (100), SAMPLE-Z (010) and EXTEST (000) capture boundary cell i from `pin_in[i]` for i < `PIN_CNT`, and capture 1 in every cell at or above `PIN_CNT`. The boundary register shifts cell 0 first.
- R9: `force_hiz` is 1 exactly while SAMPLE-Z (010) is the active instruction.
- R10: Entering ST_DR_UPDATE under a boundary instruction copies the boundary register into the update stage. `bnd_q` shows the update stage while EXTEST (000) is active and is all zeros otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-up reset, active low, asynchronous |
| tms | input | 1 | Mode input steering the controller |
| tdi | input | 1 | Serial data in |
| pin_in | input | PIN_CNT | Parallel pin values captured by the boundary register |
| tdo | output | 1 | Serial data out, launched on falling `tck` |
| tdo_en | output | 1 | Serial output enable, high in the two shift states |
| force_hiz | output | 1 | Requests high impedance on all functional outputs |
| bnd_q | output | BND_LEN | Update-stage values driven while EXTEST is active |

## Verification
The instruction-dependent output `force_hiz` and the mode-driven return to Test-Logic-Reset act in the same rising edge, because entering reset both moves the controller and reloads IDCODE. The bench loads SAMPLE-Z, enters ST_DR_SHIFT, and then holds `tms` high. It requires `force_hiz` to still be high after four edges and low after the fifth, and a following data scan must then return the identification word. A similar collision is judged at Update-IR: switching from SAMPLE/PRELOAD to EXTEST must expose, on that edge, the update-stage value preloaded by an earlier data scan.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

    typedef enum logic [3:0] {
        ST_RESET,
        ST_IDLE,
        ST_DR_SCAN,
        ST_DR_CAPTURE,
        ST_DR_SHIFT,
        ST_DR_EXIT1,
        ST_DR_PAUSE,
        ST_DR_EXIT2,
        ST_DR_UPDATE,
        ST_IR_SCAN,
        ST_IR_CAPTURE,
        ST_IR_SHIFT,
        ST_IR_EXIT1,
        ST_IR_PAUSE,
        ST_IR_EXIT2,
        ST_IR_UPDATE
    } tap_state_e;

    typedef enum logic [1:0] {
        PATH_BYP,
        PATH_ID,
        PATH_BND
    } dr_path_e;

    localparam int IR_W = 3;
    localparam int ID_W = 32;

    localparam logic [IR_W-1:0] OP_EXTEST = 3'b000;
    localparam logic [IR_W-1:0] OP_IDCODE = 3'b001;
    localparam logic [IR_W-1:0] OP_SAMPZ  = 3'b010;
    localparam logic [IR_W-1:0] OP_SAMPLE = 3'b100;

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       por_n,
    input  logic       tms,
    output tap_state_e state_q,
    output tap_state_e state_nxt
);

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) state_q <= ST_RESET;
        else        state_q <= state_nxt;
    end

    always_comb begin
        unique case (state_q)
            ST_RESET:      state_nxt = tms ? ST_RESET     : ST_IDLE;
            ST_IDLE:       state_nxt = tms ? ST_DR_SCAN   : ST_IDLE;
            ST_DR_SCAN:    state_nxt = tms ? ST_IR_SCAN   : ST_DR_CAPTURE;
            ST_DR_CAPTURE: state_nxt = tms ? ST_DR_EXIT1  : ST_DR_SHIFT;
            ST_DR_SHIFT:   state_nxt = tms ? ST_DR_EXIT1  : ST_DR_SHIFT;
            ST_DR_EXIT1:   state_nxt = tms ? ST_DR_UPDATE : ST_DR_PAUSE;
            ST_DR_PAUSE:   state_nxt = tms ? ST_DR_EXIT2  : ST_DR_PAUSE;
            ST_DR_EXIT2:   state_nxt = tms ? ST_DR_UPDATE : ST_DR_SHIFT;
            ST_DR_UPDATE:  state_nxt = tms ? ST_DR_SCAN   : ST_IDLE;
            ST_IR_SCAN:    state_nxt = tms ? ST_RESET     : ST_IR_CAPTURE;
            ST_IR_CAPTURE: state_nxt = tms ? ST_IR_EXIT1  : ST_IR_SHIFT;
            ST_IR_SHIFT:   state_nxt = tms ? ST_IR_EXIT1  : ST_IR_SHIFT;
            ST_IR_EXIT1:   state_nxt = tms ? ST_IR_UPDATE : ST_IR_PAUSE;
            ST_IR_PAUSE:   state_nxt = tms ? ST_IR_EXIT2  : ST_IR_PAUSE;
            ST_IR_EXIT2:   state_nxt = tms ? ST_IR_UPDATE : ST_IR_SHIFT;
            ST_IR_UPDATE:  state_nxt = tms ? ST_DR_SCAN   : ST_IDLE;
            default:       state_nxt = ST_RESET;
        endcase
    end

    // Checker: run length of consecutive mode-high edges, saturating at 7
    logic [2:0] ones_run;
    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n)              ones_run <= 3'd0;
        else if (!tms)           ones_run <= 3'd0;
        else if (ones_run != 3'd7) ones_run <= ones_run + 3'd1;
    end

    assert_five_ones_reset_R2: assert property (@(posedge tck) disable iff (!por_n)
        (ones_run >= 3'd5) |-> (state_q == ST_RESET));

    assert_reset_holds_R2: assert property (@(posedge tck) disable iff (!por_n)
        (state_q == ST_RESET && tms) |=> (state_q == ST_RESET));

endmodule

// File: rtl/scan_tap_ir.sv
module scan_tap_ir
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       por_n,
    input  logic       tdi,
    input  tap_state_e state_q,
    input  tap_state_e state_nxt,
    output logic       ir_tdo,
    output dr_path_e   path,
    output logic       force_hiz,
    output logic       extest_on
);

    logic [IR_W-1:0] ir_sr;
    logic [IR_W-1:0] ir_q;

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            ir_sr <= '0;
            ir_q  <= OP_IDCODE;
        end else begin
            if (state_q == ST_IR_CAPTURE)
                ir_sr <= IR_W'(1);
            else if (state_q == ST_IR_SHIFT)
                ir_sr <= {tdi, ir_sr[IR_W-1:1]};

            if (state_nxt == ST_RESET)
                ir_q <= OP_IDCODE;
            else if (state_nxt == ST_IR_UPDATE)
                ir_q <= ir_sr;
        end
    end

    assign ir_tdo = ir_sr[0];

    always_comb begin
        path      = PATH_BYP;
        force_hiz = 1'b0;
        extest_on = 1'b0;
        case (ir_q)
            OP_EXTEST: begin path = PATH_BND; extest_on = 1'b1; end
            OP_IDCODE: path = PATH_ID;
            OP_SAMPZ:  begin path = PATH_BND; force_hiz = 1'b1; end
            OP_SAMPLE: path = PATH_BND;
            default:   path = PATH_BYP;
        endcase
    end

    assert_ir_change_on_update_R5: assert property (@(posedge tck) disable iff (!por_n)
        !$stable(ir_q) |-> (state_q == ST_IR_UPDATE || state_q == ST_RESET));

    assert_ir_idcode_in_reset_R3: assert property (@(posedge tck) disable iff (!por_n)
        (state_q == ST_RESET) |-> (ir_q == OP_IDCODE));

endmodule

// File: rtl/scan_tap_dr.sv
module scan_tap_dr
    import scan_tap_pkg::*;
#(
    parameter int              BND_LEN = 8,
    parameter int              PIN_CNT = 6,
    parameter logic [ID_W-1:0] ID_VAL  = 32'h1A2B_3C4D
) (
    input  logic               tck,
    input  logic               por_n,
    input  logic               tdi,
    input  tap_state_e         state_q,
    input  tap_state_e         state_nxt,
    input  dr_path_e           path,
    input  logic [PIN_CNT-1:0] pin_in,
    output logic               dr_tdo,
    output logic [BND_LEN-1:0] upd_q
);

    logic               byp_q;
    logic [ID_W-1:0]    id_sr;
    logic [BND_LEN-1:0] bnd_sr;
    logic [BND_LEN-1:0] cap_v;

    for (genvar g = 0; g < BND_LEN; g++) begin : g_cell
        if (g < PIN_CNT) begin : g_pin
            assign cap_v[g] = pin_in[g];
        end else begin : g_fill
            assign cap_v[g] = 1'b1;
        end
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            byp_q  <= 1'b0;
            id_sr  <= '0;
            bnd_sr <= '0;
            upd_q  <= '0;
        end else begin
            if (state_q == ST_DR_CAPTURE) begin
                case (path)
                    PATH_BYP: byp_q  <= 1'b0;
                    PATH_ID:  id_sr  <= ID_VAL;
                    PATH_BND: bnd_sr <= cap_v;
                    default:  ;
                endcase
            end else if (state_q == ST_DR_SHIFT) begin
                case (path)
                    PATH_BYP: byp_q  <= tdi;
                    PATH_ID:  id_sr  <= {tdi, id_sr[ID_W-1:1]};
                    PATH_BND: bnd_sr <= {tdi, bnd_sr[BND_LEN-1:1]};
                    default:  ;
                endcase
            end

            if (state_nxt == ST_DR_UPDATE && path == PATH_BND)
                upd_q <= bnd_sr;
        end
    end

    always_comb begin
        case (path)
            PATH_ID:  dr_tdo = id_sr[0];
            PATH_BND: dr_tdo = bnd_sr[0];
            default:  dr_tdo = byp_q;
        endcase
    end

    assert_upd_only_on_update_R10: assert property (@(posedge tck) disable iff (!por_n)
        !$stable(upd_q) |-> (state_q == ST_DR_UPDATE));

endmodule

// File: rtl/scan_tap_top.sv
module scan_tap_top
    import scan_tap_pkg::*;
#(
    parameter int              BND_LEN = 8,
    parameter int              PIN_CNT = 6,
    parameter logic [ID_W-1:0] ID_VAL  = 32'h1A2B_3C4D
) (
    input  logic               tck,
    input  logic               por_n,
    input  logic               tms,
    input  logic               tdi,
    input  logic [PIN_CNT-1:0] pin_in,
    output logic               tdo,
    output logic               tdo_en,
    output logic               force_hiz,
    output logic [BND_LEN-1:0] bnd_q
);

    tap_state_e         state_q;
    tap_state_e         state_nxt;
    dr_path_e           path;
    logic               ir_tdo;
    logic               dr_tdo;
    logic               extest_on;
    logic [BND_LEN-1:0] upd_q;
    logic               in_shift;
    logic               ser_bit;

    scan_tap_fsm i_fsm (
        .tck       (tck),
        .por_n     (por_n),
        .tms       (tms),
        .state_q   (state_q),
        .state_nxt (state_nxt)
    );

    scan_tap_ir i_ir (
        .tck       (tck),
        .por_n     (por_n),
        .tdi       (tdi),
        .state_q   (state_q),
        .state_nxt (state_nxt),
        .ir_tdo    (ir_tdo),
        .path      (path),
        .force_hiz (force_hiz),
        .extest_on (extest_on)
    );

    scan_tap_dr #(
        .BND_LEN (BND_LEN),
        .PIN_CNT (PIN_CNT),
        .ID_VAL  (ID_VAL)
    ) i_dr (
        .tck       (tck),
        .por_n     (por_n),
        .tdi       (tdi),
        .state_q   (state_q),
        .state_nxt (state_nxt),
        .path      (path),
        .pin_in    (pin_in),
        .dr_tdo    (dr_tdo),
        .upd_q     (upd_q)
    );

    assign in_shift = (state_q == ST_IR_SHIFT) || (state_q == ST_DR_SHIFT);
    assign ser_bit  = (state_q == ST_IR_SHIFT) ? ir_tdo : dr_tdo;

    // Serial output launched half a cycle after the rising edge
    always_ff @(negedge tck or negedge por_n) begin
        if (!por_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo    <= ser_bit;
            tdo_en <= in_shift;
        end
    end

    assign bnd_q = extest_on ? upd_q : '0;

    assert_tdo_en_shift_R1: assert property (@(posedge tck) disable iff (!por_n)
        tdo_en == ((state_q == ST_IR_SHIFT) || (state_q == ST_DR_SHIFT)));

endmodule

// File: tb/test_scan_tap_top.sv
module test_scan_tap_top;

    localparam int          BND  = 8;
    localparam int          PINS = 6;
    localparam logic [31:0] IDV  = 32'h1A2B_3C4D;

    logic            tck   = 1'b0;
    logic            por_n = 1'b0;
    logic            tms   = 1'b1;
    logic            tdi   = 1'b1;
    logic [PINS-1:0] pins  = '0;
    logic            tdo;
    logic            tdo_en;
    logic            force_hiz;
    logic [BND-1:0]  bnd_q;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    scan_tap_top #(.BND_LEN(BND), .PIN_CNT(PINS), .ID_VAL(IDV)) i_scan_tap_top (
        .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .pin_in(pins),
        .tdo(tdo), .tdo_en(tdo_en), .force_hiz(force_hiz), .bnd_q(bnd_q)
    );

    always #4 tck = ~tck;

    always @(posedge tck) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog (R1..) actual=%0d expected<150000 cycles", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Inputs set after the falling edge; tdo/tdo_en sampled there; returns after rising edge
    task automatic tick(input logic m, input logic d, output logic o, output logic e);
        @(negedge tck);
        #1;
        tms = m;
        tdi = d;
        o = tdo;
        e = tdo_en;
        @(posedge tck);
        #1;
    endtask

    task automatic shift_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
        logic o, e;
        dout = '0;
        tick(1'b1, 1'b1, o, e);
        tick(1'b0, 1'b1, o, e);
        tick(1'b0, 1'b1, o, e);
        for (int i = 0; i < n; i++) begin
            tick(logic'(i == n - 1), din[i], o, e);
            dout[i] = o;
        end
        tick(1'b1, 1'b1, o, e);
        tick(1'b0, 1'b1, o, e);
    endtask

    task automatic shift_ir(input logic [2:0] code, output logic [2:0] cap);
        logic o, e;
        tick(1'b1, 1'b1, o, e);
        tick(1'b1, 1'b1, o, e);
        tick(1'b0, 1'b1, o, e);
        tick(1'b0, 1'b1, o, e);
        for (int i = 0; i < 3; i++) begin
            tick(logic'(i == 2), code[i], o, e);
            cap[i] = o;
        end
        tick(1'b1, 1'b1, o, e);
        tick(1'b0, 1'b1, o, e);
    endtask

    initial begin
        logic [63:0] dout;
        logic [2:0]  cap;
        logic        o, e;
        logic [2:0]  rsv [4];
        rsv[0] = 3'b011; rsv[1] = 3'b101; rsv[2] = 3'b110; rsv[3] = 3'b111;

        repeat (3) @(negedge tck);
        #2 por_n = 1'b1;
        #1;
        chk("R2 reset tdo_en", 64'(tdo_en), 64'd0);
        chk("R9 reset force_hiz", 64'(force_hiz), 64'd0);
        chk("R10 reset bnd_q", 64'(bnd_q), 64'd0);

        tick(1'b0, 1'b1, o, e);
        shift_dr(32, 64'h0, dout);
        chk("R3 R7 IDCODE after reset", dout, 64'(IDV));
        chk("R1 tdo_en low in idle", 64'(tdo_en), 64'd0);

        // R1: enable rises on falling edge; tdo holds across rising edge
        tick(1'b1, 1'b1, o, e);
        tick(1'b0, 1'b1, o, e);
        tick(1'b0, 1'b1, o, e);
        chk("R1 tdo_en still low just after entering shift", 64'(tdo_en), 64'd0);
        tick(1'b0, 1'b1, o, e);
        chk("R1 tdo_en high in shift", 64'(e), 64'd1);
        chk("R1 first id bit", 64'(o), 64'(IDV[0]));
        chk("R1 tdo unchanged at rising edge", 64'(tdo), 64'(IDV[0]));
        tick(1'b0, 1'b1, o, e);
        chk("R1 second id bit after falling edge", 64'(o), 64'(IDV[1]));
        for (int k = 0; k < 5; k++) tick(1'b1, 1'b1, o, e);
        tick(1'b0, 1'b1, o, e);

        // R4 / R6: reserved codes and all-ones act as bypass
        foreach (rsv[j]) begin
            shift_ir(rsv[j], cap);
            chk($sformatf("R4 capture-IR value code %0b", rsv[j]), 64'(cap), 64'd1);
            shift_dr(6, 64'b101101, dout);
            chk($sformatf("R6 bypass code %0b", rsv[j]), dout, 64'b011010);
        end

        // R8: sweep all pin patterns under SAMPLE/PRELOAD
        shift_ir(3'b100, cap);
        for (int p = 0; p < (1 << PINS); p++) begin
            pins = PINS'(p);
            shift_dr(BND, 64'h0, dout);
            chk($sformatf("R8 sample pins %0h", p), dout, {56'd0, 2'b11, PINS'(p)});
            chk("R10 bnd_q zero under SAMPLE", 64'(bnd_q), 64'd0);
        end

        // R10: preload then EXTEST presents update stage
        for (int v = 0; v < 4; v++) begin
            logic [BND-1:0] pv;
            pv = BND'(8'hA5 ^ (v * 8'h33));
            shift_ir(3'b100, cap);
            shift_dr(BND, 64'(pv), dout);
            chk("R10 bnd_q zero before EXTEST", 64'(bnd_q), 64'd0);
            shift_ir(3'b000, cap);
            chk("R10 EXTEST drives preload", 64'(bnd_q), 64'(pv));
            pins = PINS'(6'h15 + v);
            shift_dr(BND, 64'(~pv), dout);
            chk("R8 EXTEST captures pins", dout, {56'd0, 2'b11, PINS'(6'h15 + v)});
            chk("R10 EXTEST update after scan", 64'(bnd_q), 64'(BND'(~pv)));
        end

        // R5: instruction held until Update-IR
        tick(1'b1, 1'b1, o, e);
        tick(1'b1, 1'b1, o, e);
        tick(1'b0, 1'b1, o, e);
        tick(1'b0, 1'b1, o, e);
        tick(1'b0, 1'b0, o, e);
        tick(1'b0, 1'b1, o, e);
        tick(1'b1, 1'b0, o, e);
        tick(1'b0, 1'b1, o, e);
        chk("R5 force_hiz low in Pause-IR", 64'(force_hiz), 64'd0);
        chk("R5 old EXTEST still active in Pause-IR", 64'(bnd_q != '0), 64'd1);
        tick(1'b1, 1'b1, o, e);
        chk("R5 force_hiz low in Exit2-IR", 64'(force_hiz), 64'd0);
        tick(1'b1, 1'b1, o, e);
        chk("R9 force_hiz high after Update-IR", 64'(force_hiz), 64'd1);
        chk("R10 bnd_q zero under SAMPLE-Z", 64'(bnd_q), 64'd0);
        tick(1'b0, 1'b1, o, e);

        pins = 6'h2A;
        shift_dr(BND, 64'h0, dout);
        chk("R8 SAMPLE-Z capture", dout, {56'd0, 2'b11, 6'h2A});
        chk("R9 force_hiz held", 64'(force_hiz), 64'd1);

        // R2: mode-driven reset from Shift-DR, coinciding with SAMPLE-Z release
        tick(1'b1, 1'b1, o, e);
        tick(1'b0, 1'b1, o, e);
        tick(1'b0, 1'b1, o, e);
        for (int k = 0; k < 4; k++) tick(1'b1, 1'b1, o, e);
        chk("R2 four ones not yet reset", 64'(force_hiz), 64'd1);
        tick(1'b1, 1'b1, o, e);
        chk("R2 R3 fifth one reaches reset", 64'(force_hiz), 64'd0);
        tick(1'b0, 1'b1, o, e);
        shift_dr(32, 64'h0, dout);
        chk("R3 IDCODE after mode reset", dout, 64'(IDV));

        // R2: power-up reset during SAMPLE-Z
        shift_ir(3'b010, cap);
        chk("R9 SAMPLE-Z reloaded", 64'(force_hiz), 64'd1);
        @(negedge tck);
        #1 por_n = 1'b0;
        #3;
        chk("R2 por clears force_hiz", 64'(force_hiz), 64'd0);
        @(negedge tck);
        #2 por_n = 1'b1;
        tick(1'b0, 1'b1, o, e);
        shift_dr(32, 64'h0, dout);
        chk("R2 IDCODE after por", dout, 64'(IDV));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule